// File: doc/BRIEF.md
# Buffered Burst Word Programmer

This block sits between a host write port and the program port of a 16-bit word array. A host write whose low byte equals 10h, made while the block is idle, puts it into buffered loading. The host then sends exactly 32 data writes back to back, with no status polling in between. Every one of those writes carries the same start address, which must sit on a 32-word boundary. The data words go into a 32-entry internal buffer. A stream shorter than 32 words is filled out with FFFFh entries, and such an entry leaves its array word untouched.

Once the 32nd write is taken, the block raises busy. It then works through the buffer in ascending order, with no processor involvement. Each non-pad word i goes to the array at the start address plus i, using a request/acknowledge handshake. If the start address was misaligned, or any later write used a different address, the block sets a fault flag, programs nothing and returns to idle.

While the block is loading or programming, foreground reads to the bank that holds the burst are refused. Only reads that target another bank are granted. The bank is the top address bits of the activation write's address.

Top module: `bps_burst_prog`

## Requirements
- R1: After reset, busy, fault and arr_req are 0, and rd_grant follows rd_en for any address.
- R2: In idle, a write with wr_data[7:0] = 10h starts loading. A write with any other low byte is ignored: no request is raised, busy stays 0 and reads are not gated.
- R3: During loading, each cycle with wr_en stores one buffer entry. busy stays 0 through the first 31 entries and reads 1 in the cycle after the 32nd entry is taken.
- R4: If the first buffered write has a nonzero value in address bits [4:0], then after the 32nd write fault is 1, busy stays 0 and no array request is made.
- R5: If any buffered write after the first carries an address different from the first, the outcome is the same as in R4.
- R6: Buffer entry i, holding the i-th buffered data word, is written to array address start + i. Entries are handled in increasing i from 0 to 31, one transfer for each cycle in which arr_req and arr_ack are both 1.
- R7: An entry equal to FFFFh causes no array request.
- R8: While arr_req is 1 and arr_ack is 0, arr_req, arr_addr and arr_data hold their values into the next cycle.
- R9: busy falls after the final entry, either its transfer or its skip. The block is then idle and accepts a new activation.
- R10: While loading or busy, rd_grant is 1 only if rd_en is 1 and rd_addr[ADDR_W-1:ADDR_W-3] differs from the same bits of the activation write's address. In idle, rd_grant equals rd_en.
- R11: Host writes made while busy, including 10h commands, are ignored.
- R12: An activation command clears fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 22 | Host write address |
| wr_data | input | 16 | Host write data or command byte |
| rd_en | input | 1 | Foreground read request |
| rd_addr | input | 22 | Foreground read address |
| rd_grant | output | 1 | Read permitted this cycle |
| busy | output | 1 | Buffer being streamed into the array |
| fault | output | 1 | Last burst rejected by the address checks |
| arr_req | output | 1 | Array word program request |
| arr_addr | output | 22 | Array word address |
| arr_data | output | 16 | Array word data |
| arr_ack | input | 1 | Array accepts the current word |

## Verification
Two pairs of functions can land in the same cycle. A foreground read can arrive together with a buffered write, including the 32nd write that turns busy on. A stray host command can arrive while the array handshake is stalled. The bench makes a random read probe, to the locked bank or to another bank, in every loading and busy cycle, including the one carrying the last buffered write, and compares rd_grant with the expected bank rule. It also sends an activation command in the middle of programming. Afterwards it compares the complete log of array transfers against the expected (address, data) list, which shows that the command had no effect.

// File: rtl/bps_pkg.sv
package bps_pkg;

    localparam int BPS_ADDR_W = 22;
    localparam int BPS_DATA_W = 16;
    localparam int BPS_DEPTH  = 32;
    localparam int BPS_BANK_W = 3;
    localparam logic [7:0] BPS_CMD = 8'h10;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_LOAD = 2'd1,
        S_PROG = 2'd2
    } bps_state_e;

    function automatic logic cmd_match(input logic [7:0] b);
        return b == BPS_CMD;
    endfunction

endpackage

// File: rtl/bps_wbuf.sv
module bps_wbuf #(
    parameter int DATA_W = bps_pkg::BPS_DATA_W,
    parameter int DEPTH  = bps_pkg::BPS_DEPTH,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] word_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (we && (widx == IDX_W'(g)))
                word_q[g] <= wdata;
        end
    end

    assign rdata = word_q[ridx];

endmodule

// File: rtl/bps_rgate.sv
module bps_rgate #(
    parameter int BANK_W = bps_pkg::BPS_BANK_W
) (
    input  logic              active,
    input  logic [BANK_W-1:0] lock_bank,
    input  logic              rd_en,
    input  logic [BANK_W-1:0] rd_bank,
    output logic              rd_grant
);

    always_comb begin
        rd_grant = rd_en;
        if (active && (rd_bank == lock_bank))
            rd_grant = 1'b0;
    end

endmodule

// File: rtl/bps_ctl.sv
module bps_ctl
    import bps_pkg::*;
#(
    parameter int ADDR_W = BPS_ADDR_W,
    parameter int DATA_W = BPS_DATA_W,
    parameter int DEPTH  = BPS_DEPTH,
    parameter int BANK_W = BPS_BANK_W,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_cmd,
    input  logic [DATA_W-1:0] cur_word,
    input  logic              arr_ack,
    output logic              buf_we,
    output logic [IDX_W-1:0]  idx,
    output logic              active,
    output logic [BANK_W-1:0] lock_bank,
    output logic              busy,
    output logic              fault,
    output logic              arr_req,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_data
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    bps_state_e        st_q;
    logic [IDX_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] base_q;
    logic              err_q;
    logic              fault_q;
    logic [BANK_W-1:0] bank_q;

    logic addr_bad, err_nx, word_pad, step;

    always_comb begin
        if (cnt_q == '0)
            addr_bad = (wr_addr[IDX_W-1:0] != '0);
        else
            addr_bad = (wr_addr != base_q);
        err_nx   = err_q | addr_bad;
        word_pad = &cur_word;
        step     = (st_q == S_PROG) && (word_pad || arr_ack);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= S_IDLE;
            cnt_q   <= '0;
            base_q  <= '0;
            err_q   <= 1'b0;
            fault_q <= 1'b0;
            bank_q  <= '0;
        end else begin
            unique case (st_q)
                S_IDLE: begin
                    if (wr_en && cmd_match(wr_cmd)) begin
                        st_q    <= S_LOAD;
                        cnt_q   <= '0;
                        err_q   <= 1'b0;
                        fault_q <= 1'b0;
                        bank_q  <= wr_addr[ADDR_W-1 -: BANK_W];
                    end
                end
                S_LOAD: begin
                    if (wr_en) begin
                        if (cnt_q == '0)
                            base_q <= wr_addr;
                        if (cnt_q == LAST) begin
                            cnt_q <= '0;
                            err_q <= 1'b0;
                            if (err_nx) begin
                                st_q    <= S_IDLE;
                                fault_q <= 1'b1;
                            end else begin
                                st_q <= S_PROG;
                            end
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                            err_q <= err_nx;
                        end
                    end
                end
                S_PROG: begin
                    if (step) begin
                        if (cnt_q == LAST) begin
                            st_q  <= S_IDLE;
                            cnt_q <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end

    assign buf_we    = (st_q == S_LOAD) && wr_en;
    assign idx       = cnt_q;
    assign active    = (st_q != S_IDLE);
    assign lock_bank = bank_q;
    assign busy      = (st_q == S_PROG);
    assign fault     = fault_q;
    assign arr_req   = (st_q == S_PROG) && !word_pad;
    assign arr_addr  = base_q + ADDR_W'(cnt_q);
    assign arr_data  = cur_word;

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (arr_req && !arr_ack) |=> (arr_req && $stable(arr_addr) && $stable(arr_data)));

    // R7
    no_pad_req_chk: assert property (@(posedge clk) disable iff (rst)
        arr_req |-> (arr_data != {DATA_W{1'b1}}));

    // R3
    busy_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(st_q == S_LOAD && wr_en));

    // R4
    fault_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        fault |-> (!busy && !arr_req));

    // R9
    busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (st_q == S_IDLE && !arr_req));

endmodule

// File: rtl/bps_burst_prog.sv
module bps_burst_prog
    import bps_pkg::*;
#(
    parameter int ADDR_W = BPS_ADDR_W,
    parameter int DATA_W = BPS_DATA_W,
    parameter int DEPTH  = BPS_DEPTH,
    parameter int BANK_W = BPS_BANK_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_grant,
    output logic              busy,
    output logic              fault,
    output logic              arr_req,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_data,
    input  logic              arr_ack
);

    localparam int IDX_W = $clog2(DEPTH);

    logic              buf_we;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] cur_word;
    logic              active;
    logic [BANK_W-1:0] lock_bank;

    bps_ctl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .BANK_W(BANK_W)
    ) u_ctl (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_cmd(wr_data[7:0]),
        .cur_word(cur_word), .arr_ack(arr_ack),
        .buf_we(buf_we), .idx(idx), .active(active), .lock_bank(lock_bank),
        .busy(busy), .fault(fault),
        .arr_req(arr_req), .arr_addr(arr_addr), .arr_data(arr_data)
    );

    bps_wbuf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_buf (
        .clk(clk), .we(buf_we), .widx(idx), .wdata(wr_data),
        .ridx(idx), .rdata(cur_word)
    );

    bps_rgate #(.BANK_W(BANK_W)) u_gate (
        .active(active), .lock_bank(lock_bank),
        .rd_en(rd_en), .rd_bank(rd_addr[ADDR_W-1 -: BANK_W]),
        .rd_grant(rd_grant)
    );

    // R10
    grant_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        rd_grant |-> rd_en);

    // R6
    req_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
        arr_req |-> busy);

endmodule

// File: tb/sim_bps_burst_prog.sv
`timescale 1ns/1ps
module sim_bps_burst_prog;

    localparam int AW = 22;
    localparam int DW = 16;
    localparam int N  = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic          rd_grant, busy, fault, arr_req;
    logic [AW-1:0] arr_addr;
    logic [DW-1:0] arr_data;
    logic          arr_ack = 1'b0;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic [AW-1:0] la [0:63];
    logic [DW-1:0] ld [0:63];
    int            log_n = 0;
    logic [DW-1:0] dat [0:N-1];

    always #2.5 clk = ~clk;

    bps_burst_prog u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_grant(rd_grant),
        .busy(busy), .fault(fault), .arr_req(arr_req), .arr_addr(arr_addr),
        .arr_data(arr_data), .arr_ack(arr_ack)
    );

    always @(negedge clk) arr_ack = arr_req && (($urandom % 3) != 0);

    always @(posedge clk) begin
        cyc++;
        if (arr_req && arr_ack && log_n < 64) begin
            la[log_n] = arr_addr;
            ld[log_n] = arr_data;
            log_n++;
        end
    end

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #900000;
        fails++;
        $display("FAIL watchdog expired: act=running exp=finished");
        finish_run();
    end

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic exp_grant(input logic en, input logic act_md,
                                       input logic [AW-1:0] ra, input logic [AW-1:0] ca);
        if (!en) return 1'b0;
        if (!act_md) return 1'b1;
        return ra[AW-1 -: 3] != ca[AW-1 -: 3];
    endfunction

    function automatic logic [AW-1:0] pick_read(input logic [AW-1:0] ca);
        logic [AW-1:0] r;
        r = AW'($urandom);
        if ($urandom % 2) r[AW-1 -: 3] = ca[AW-1 -: 3];
        return r;
    endfunction

    task automatic probe_read(input logic act_md, input logic [AW-1:0] ca, input string req);
        rd_en   = ($urandom % 4) != 0;
        rd_addr = pick_read(ca);
        #1;
        chk(rd_grant == exp_grant(rd_en, act_md, rd_addr, ca), req, "read gate",
            {31'd0, rd_grant}, {31'd0, exp_grant(rd_en, act_md, rd_addr, ca)});
    endtask

    // One full burst: activation, 32 buffered writes, programming, log compare.
    task automatic run_burst(input logic [AW-1:0] ca, input logic [AW-1:0] st,
                             input int bad_i, input logic [AW-1:0] bad_a,
                             input int pad_pct, input int short_n, input logic poke);
        logic ef;
        int   k, w;
        for (int i = 0; i < N; i++) begin
            dat[i] = DW'($urandom);
            if (i >= short_n || int'($urandom % 100) < pad_pct) dat[i] = 16'hFFFF;
        end
        ef = (st[4:0] != 5'd0) || (bad_i > 0 && bad_a != st);
        log_n = 0;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = ca; wr_data = {8'($urandom), 8'h10};
        probe_read(1'b0, ca, "R10");
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            if (i == 0) chk(fault == 1'b0, "R12", "fault after command", {31'd0, fault}, 0);
            wr_en = 1'b1;
            wr_addr = (i == bad_i) ? bad_a : st;
            wr_data = dat[i];
            probe_read(1'b1, ca, "R10");
            chk(busy == 1'b0, "R3", "busy during load", {31'd0, busy}, 0);
        end
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        chk(busy == !ef, "R3", "busy after 32nd", {31'd0, busy}, {31'd0, !ef});
        chk(fault == ef, "R4", "fault after load", {31'd0, fault}, {31'd0, ef});
        w = 0;
        while (busy && w < 3000) begin
            probe_read(1'b1, ca, "R10");
            if (poke && w == 3) begin
                wr_en = 1'b1; wr_addr = st + 22'd1; wr_data = 16'h0010;
            end else begin
                wr_en = 1'b0;
            end
            @(negedge clk);
            #1;
            w++;
        end
        wr_en = 1'b0;
        chk(busy == 1'b0, "R9", "busy cleared", {31'd0, busy}, 0);
        k = 0;
        if (!ef) begin
            for (int i = 0; i < N; i++) begin
                if (dat[i] != 16'hFFFF) begin
                    if (k < log_n) begin
                        chk(la[k] == st + AW'(i), "R6", "array address",
                            {10'd0, la[k]}, {10'd0, st + AW'(i)});
                        chk(ld[k] == dat[i], "R6", "array data",
                            {16'd0, ld[k]}, {16'd0, dat[i]});
                    end
                    k++;
                end
            end
        end
        chk(log_n == k, ef ? "R5" : "R7", "transfer count", log_n, k);
        probe_read(1'b0, ca, "R9");
    endtask

    initial begin
        logic [AW-1:0] s;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(busy == 1'b0, "R1", "busy at reset", {31'd0, busy}, 0);
        chk(fault == 1'b0, "R1", "fault at reset", {31'd0, fault}, 0);
        chk(arr_req == 1'b0, "R1", "req at reset", {31'd0, arr_req}, 0);
        rd_en = 1'b1; rd_addr = 22'h3FFFFF; #1;
        chk(rd_grant == 1'b1, "R1", "grant at reset", {31'd0, rd_grant}, 1);

        // R2: non-command idle write ignored
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 22'h100000; wr_data = 16'h0040;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b1; rd_addr = 22'h100000; #1;
        chk(rd_grant == 1'b1 && busy == 1'b0 && arr_req == 1'b0, "R2", "ignored write",
            {29'd0, rd_grant, busy, arr_req}, 32'h4);

        // Directed bursts
        run_burst(22'h200040, 22'h200040, -1, '0, 0, N, 1'b0);        // R6 all data
        run_burst(22'h080000, 22'h0803E0, -1, '0, 30, N, 1'b1);       // R7 R11 pads + poke
        run_burst(22'h1C0000, 22'h1C0100, -1, '0, 0, 5, 1'b0);        // R7 short stream
        run_burst(22'h300000, 22'h300000, -1, '0, 0, 0, 1'b0);        // R7 all pad
        run_burst(22'h040000, 22'h040003, -1, '0, 0, N, 1'b0);        // R4 misaligned
        run_burst(22'h040000, 22'h040020, 31, 22'h040040, 0, N, 1'b0); // R5 mismatch last
        run_burst(22'h040000, 22'h040020, -1, '0, 10, N, 1'b0);       // R12 R9 recover

        // Random bursts
        for (int r = 0; r < 6; r++) begin
            s = AW'($urandom) & ~22'h1F;
            run_burst(AW'($urandom), s, (r == 4) ? 7 : -1, s ^ 22'h20,
                      int'($urandom % 50), N, r[0]);
        end
        finish_run();
    end

endmodule